// File: doc/BRIEF.md
# SECDED Packet Word Decoder

This block sits between a word FIFO and a consumer that must only ever see clean data. The input is a stream of 32-bit words grouped into five-word packets. The first four words of a packet are data. The fifth word carries seven check bits for each of those four data words. The block gathers a whole packet first, because the check bits arrive last. It then decodes one data word per clock, corrects any single-bit error, and presents the corrected word on its output.

When a word cannot be corrected, the block stops. It sets a sticky fatal flag, emits nothing further and refuses input until it receives a start pulse. A saturating counter records how many words needed a single-bit correction. This count includes words whose flipped bit was one of their own check bits.

The code is an odd-column-weight SECDED(39,32) code. Data bit i is given the i-th 7-bit value of weight three, counting in ascending numeric order. Check bit j is the exclusive OR of every data bit whose column has bit j set.

Top module: `pkt_secded_dec`

## Requirements
- R1: After reset, out_valid is 0, fatal_error is 0, corr_count is 0 and in_ready is 1 while start is low.
- R2: A packet is five accepted words: data words 0 to 3, then a check word. The check bits of data word i sit in bits [7i+6:7i] of the check word. Data bit i uses the i-th weight-3 7-bit column in ascending numeric order. Check bit j is the XOR of the data bits whose column has bit j set. An error-free packet is output as its four data words, in order.
- R3: A word is accepted only in a cycle where in_valid and in_ready are both high, and idle cycles between words are allowed. in_ready is low from the edge that accepts the fifth word until the edge that registers the fourth output. No output appears before the fifth word is accepted.
- R4: The four data words are output on the four clock edges that follow the edge accepting the check word, one word per edge, with out_valid high for exactly those four cycles.
- R5: A single flipped data bit in any of the 32 positions of any data word is corrected before the word is output.
- R6: A single flipped check bit leaves its data word unchanged at the output, and the word still counts as corrected.
- R7: A syndrome that matches no column is uncorrectable. This covers any two flipped bits, and also all seven check bits of a word flipped. On such a syndrome, fatal_error rises on the edge where that word would have been output. The word is not output, no later word is output, and in_ready stays low.
- R8: Any nonzero bit in check-word bits [31:28] is treated as uncorrectable, and the packet outputs none of its words.
- R9: in_ready returns high in the cycle in which the fourth word of a packet is valid, and the next packet is then gathered.
- R10: corr_count increases by one for each output word that needed a correction and saturates at 2^CNT_W-1.
- R11: A start pulse clears fatal_error, drops any partly gathered packet and resumes gathering on the next cycle. It leaves corr_count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clears the fatal flag and restarts packet gathering |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Block accepts a word this cycle |
| out_valid | output | 1 | Corrected data word present |
| out_data | output | 32 | Corrected data word |
| fatal_error | output | 1 | Sticky uncorrectable-error flag |
| corr_count | output | CNT_W | Saturating count of corrected words |

## Verification
A gather index that slips by one position moves the check word into a data slot. That error shows at the ports within one packet: words come out wrong, or fatal_error rises on the first output edge. A column table that differs from the specified ordering shows as miscorrected data or a false fatal on the first swept bit that uses the bad column. An emit sequencer that skips or repeats an index changes the count of out_valid cycles per packet, which the bench sees four edges after the check word is accepted. A counter that wraps instead of saturating shows as a drop in corr_count once the ceiling is reached.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W   = 32;
  localparam int CHK_W    = 7;
  localparam int DATA_WPP = 4;
  localparam int PKT_WPP  = DATA_WPP + 1;
  localparam int PAD_LO   = CHK_W * DATA_WPP;

  // i-th weight-3 column, ascending numeric order
  function automatic logic [CHK_W-1:0] hcol(input int idx);
    int k;
    logic [CHK_W-1:0] r;
    k = 0;
    r = '0;
    for (int v = 0; v < (1 << CHK_W); v++) begin
      if ($countones(CHK_W'(v)) == 3) begin
        if (k == idx) r = CHK_W'(v);
        k++;
      end
    end
    return r;
  endfunction

  function automatic logic is_one_bit(input logic [CHK_W-1:0] s);
    return (s != '0) && ((s & (s - 1'b1)) == '0);
  endfunction
endpackage

// File: rtl/pkt_gather.sv
module pkt_gather #(
  parameter int NW = secded_pkg::PKT_WPP,
  parameter int DW = secded_pkg::DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   take,
  input  logic [DW-1:0]          din,
  output logic [NW-1:0][DW-1:0]  words,
  output logic                   full
);
  localparam int IW = $clog2(NW);
  localparam logic [IW-1:0] LAST = IW'(NW - 1);

  logic [IW-1:0] idx;

  assign full = take && (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      idx <= '0;
    end else if (take) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words <= '0;
    end else if (take && !clr) begin
      words[idx] <= din;
    end
  end

  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);
endmodule

// File: rtl/word_fix.sv
module word_fix #(
  parameter int DW = secded_pkg::DATA_W,
  parameter int CW = secded_pkg::CHK_W
) (
  input  logic [DW-1:0] d_in,
  input  logic [CW-1:0] c_in,
  output logic [DW-1:0] d_out,
  output logic [CW-1:0] syn,
  output logic          ev_corr,
  output logic          ev_fail
);
  logic [CW-1:0] colv [DW];
  logic [DW-1:0] hit;
  logic [CW-1:0] calc;
  logic          chk_hit;

  for (genvar g = 0; g < DW; g++) begin : g_col
    localparam logic [CW-1:0] COL = secded_pkg::hcol(g);
    assign colv[g] = COL;
    assign hit[g]  = (syn == COL);
  end

  always_comb begin
    calc = '0;
    for (int i = 0; i < DW; i++) begin
      if (d_in[i]) calc = calc ^ colv[i];
    end
  end

  assign syn     = calc ^ c_in;
  assign chk_hit = secded_pkg::is_one_bit(syn);
  assign d_out   = d_in ^ hit;
  assign ev_corr = (|hit) || chk_hit;
  assign ev_fail = (syn != '0) && !ev_corr;

  always_comb begin
    if (!$isunknown(syn)) begin
      a_r5_one_flip: assert ($onehot0(hit));
      a_r6_chk_keeps_data: assert (!chk_hit || (d_out == d_in));
    end
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (inc && (q != MAX)) q <= q + 1'b1;
  end

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (q == MAX) |=> (q == MAX));
  a_r10_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (q != MAX) |=> (q >= $past(q)));
  a_r10_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(q));
endmodule

// File: rtl/pkt_secded_dec.sv
module pkt_secded_dec #(
  parameter int CNT_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic                              in_valid,
  input  logic [secded_pkg::DATA_W-1:0]     in_data,
  output logic                              in_ready,
  output logic                              out_valid,
  output logic [secded_pkg::DATA_W-1:0]     out_data,
  output logic                              fatal_error,
  output logic [CNT_W-1:0]                  corr_count
);
  import secded_pkg::*;

  localparam int EW = $clog2(DATA_WPP);
  localparam logic [EW-1:0] E_LAST = EW'(DATA_WPP - 1);

  typedef enum logic [1:0] {S_GATHER, S_EMIT, S_HALT} st_t;

  st_t                              state;
  logic [EW-1:0]                    emit_idx;
  logic                             take;
  logic                             gather_full;
  logic [PKT_WPP-1:0][DATA_W-1:0]   words;
  logic [DATA_W-1:0]                chkw;
  logic [CHK_W-1:0]                 c_arr [DATA_WPP];
  logic [DATA_W-1:0]                cur_d;
  logic [CHK_W-1:0]                 cur_c;
  logic [DATA_W-1:0]                fix_d;
  logic [CHK_W-1:0]                 fix_syn;
  logic                             ev_corr;
  logic                             ev_fail;
  logic                             pad_bad;
  logic                             ev_stop;
  logic                             ev_emit;
  logic                             cnt_inc;

  assign in_ready = (state == S_GATHER) && !start;
  assign take     = in_valid && in_ready;

  pkt_gather #(.NW(PKT_WPP), .DW(DATA_W)) gather_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .take  (take),
    .din   (in_data),
    .words (words),
    .full  (gather_full)
  );

  assign chkw = words[PKT_WPP-1];

  for (genvar g = 0; g < DATA_WPP; g++) begin : g_slice
    assign c_arr[g] = chkw[g*CHK_W +: CHK_W];
  end

  assign cur_d = words[emit_idx];
  assign cur_c = c_arr[emit_idx];

  word_fix #(.DW(DATA_W), .CW(CHK_W)) fix_i (
    .d_in    (cur_d),
    .c_in    (cur_c),
    .d_out   (fix_d),
    .syn     (fix_syn),
    .ev_corr (ev_corr),
    .ev_fail (ev_fail)
  );

  assign pad_bad = |chkw[DATA_W-1:PAD_LO];
  assign ev_stop = (state == S_EMIT) && !start && (ev_fail || pad_bad);
  assign ev_emit = (state == S_EMIT) && !start && !ev_stop;
  assign cnt_inc = ev_emit && ev_corr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_GATHER;
      emit_idx    <= '0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      fatal_error <= 1'b0;
    end else if (start) begin
      state       <= S_GATHER;
      emit_idx    <= '0;
      out_valid   <= 1'b0;
      fatal_error <= 1'b0;
    end else begin
      unique case (state)
        S_GATHER: begin
          out_valid <= 1'b0;
          emit_idx  <= '0;
          if (gather_full) state <= S_EMIT;
        end
        S_EMIT: begin
          if (ev_stop) begin
            out_valid   <= 1'b0;
            fatal_error <= 1'b1;
            state       <= S_HALT;
          end else begin
            out_valid <= 1'b1;
            out_data  <= fix_d;
            emit_idx  <= emit_idx + 1'b1;
            if (emit_idx == E_LAST) state <= S_GATHER;
          end
        end
        default: begin
          out_valid <= 1'b0;
        end
      endcase
    end
  end

  sat_counter #(.W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (cnt_inc),
    .q     (corr_count)
  );

  a_r7_fatal_silent: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_error |-> !out_valid);
  a_r7_halt_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HALT) |-> (fatal_error && !in_ready));
  a_r4_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EMIT && emit_idx == '0 && !start) |=> (out_valid ^ fatal_error));
  a_r3_quiet_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    (gather_full && !start) |=> !out_valid);
  a_r8_pad_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EMIT && pad_bad && !start) |=> (!out_valid && fatal_error));
endmodule

// File: tb/pkt_secded_dec_tb.sv
module pkt_secded_dec_tb_top;
  localparam int CW_T = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        fatal_error;
  logic [7:0]  corr_count;

  always #2.5 clk = ~clk;

  pkt_secded_dec #(.CNT_W(CW_T)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .fatal_error(fatal_error), .corr_count(corr_count)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [6:0]  bcol [32];
  logic [31:0] pd [4];
  logic [31:0] ed [4];
  logic [6:0]  ec [4];
  logic [3:0]  pad;
  logic [31:0] cap [8];
  int          cap_n = 0;
  int          exp_cnt = 0;

  always @(negedge clk) begin
    if (out_valid) begin
      cap[cap_n % 8] = out_data;
      cap_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] bchk(input logic [31:0] d);
    logic [6:0] c = '0;
    for (int i = 0; i < 32; i++) if (d[i]) c ^= bcol[i];
    return c;
  endfunction

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic clear_err();
    for (int i = 0; i < 4; i++) begin ed[i] = '0; ec[i] = '0; end
    pad = '0;
  endtask

  // sends pd with error masks; checks outputs, fatal and count
  task automatic send_check(input string tag);
    logic [31:0] cw;
    int fail_at, wt, n_corr;
    cw = '0;
    for (int i = 0; i < 4; i++) cw[7*i +: 7] = bchk(pd[i]) ^ ec[i];
    cw[31:28] = pad;
    fail_at = (pad != 0) ? 0 : 4;
    n_corr = 0;
    for (int i = 0; i < 4; i++) begin
      wt = $countones(ed[i]) + $countones(ec[i]);
      if (fail_at == 4 && wt >= 2) fail_at = i;
      if (i < fail_at && wt == 1) n_corr++;
    end
    cap_n = 0;
    for (int i = 0; i < 4; i++) push(pd[i] ^ ed[i]);
    push(cw);
    repeat (6) @(negedge clk);
    check(cap_n == fail_at, {tag, " word count"}, cap_n, fail_at);
    for (int i = 0; i < fail_at && i < cap_n; i++)
      check(cap[i] == pd[i], {tag, " data"}, cap[i], pd[i]);
    check(fatal_error == (fail_at < 4), {tag, " fatal"}, fatal_error, (fail_at < 4));
    exp_cnt = (exp_cnt + n_corr > 255) ? 255 : exp_cnt + n_corr;
    check(corr_count == exp_cnt, {tag, " R10 count"}, corr_count, exp_cnt);
    if (fail_at < 4) begin
      check(!in_ready, {tag, " R7 ready low"}, in_ready, 0);
      pulse_start();
      @(negedge clk);
      check(!fatal_error && in_ready, {tag, " R11 cleared"}, {fatal_error, in_ready}, 1);
      check(corr_count == exp_cnt, {tag, " R11 count kept"}, corr_count, exp_cnt);
    end
  endtask

  function automatic void new_data(input int s);
    for (int i = 0; i < 4; i++) pd[i] = 32'h9E37_79B9 * (s * 4 + i + 1) ^ (32'hA5A5_0000 >> i);
  endfunction

  initial begin
    begin
      int k = 0;
      for (int c = 2; c < 7; c++)
        for (int b = 1; b < c; b++)
          for (int a = 0; a < b; a++)
            if (k < 32) begin bcol[k] = 7'((1 << a) | (1 << b) | (1 << c)); k++; end
    end
    clear_err();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!out_valid && !fatal_error && corr_count == 0 && in_ready, "R1 reset",
          {out_valid, fatal_error, in_ready}, 3'b001);

    // R2 R3 R4 R9 timing on a clean packet
    new_data(0);
    cap_n = 0;
    for (int i = 0; i < 4; i++) push(pd[i]);
    @(negedge clk);
    check(cap_n == 0 && !out_valid, "R3 no early output", out_valid, 0);
    push(bchk(pd[0]) | (32'(bchk(pd[1])) << 7) | (32'(bchk(pd[2])) << 14) | (32'(bchk(pd[3])) << 21));
    @(negedge clk);
    check(!out_valid && !in_ready, "R3 quiet after check word", {out_valid, in_ready}, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid && out_data == pd[i], "R4 R2 word per edge", out_data, pd[i]);
      if (i < 3) check(!in_ready, "R3 ready low while emitting", in_ready, 0);
    end
    check(in_ready, "R9 ready back with last word", in_ready, 1);
    @(negedge clk);
    check(!out_valid, "R4 exactly four", out_valid, 0);

    // R3 gaps between words
    new_data(1);
    begin
      logic [31:0] cw;
      cw = '0;
      for (int i = 0; i < 4; i++) cw[7*i +: 7] = bchk(pd[i]);
      cap_n = 0;
      for (int i = 0; i < 4; i++) begin repeat (i + 1) @(negedge clk); push(pd[i]); end
      repeat (3) @(negedge clk);
      push(cw);
      repeat (6) @(negedge clk);
      check(cap_n == 4 && cap[3] == pd[3], "R3 idle gaps", cap[3], pd[3]);
    end

    // R5 every data bit of every word
    for (int b = 0; b < 32; b++)
      for (int w = 0; w < 4; w++) begin
        new_data(b + w + 2); clear_err();
        ed[w][b] = 1'b1;
        send_check("R5 data single");
      end
    // R6 every check bit
    for (int b = 0; b < 7; b++)
      for (int w = 0; w < 4; w++) begin
        new_data(b * 3 + w); clear_err();
        ec[w][b] = 1'b1;
        send_check("R6 check single");
      end
    // R10 saturation: four corrections per packet
    for (int p = 0; p < 28; p++) begin
      new_data(p + 40); clear_err();
      ed[0][p] = 1'b1; ec[1][p % 7] = 1'b1; ed[2][31 - p] = 1'b1; ed[3][(p * 5) % 32] = 1'b1;
      send_check("R10 saturate");
    end
    check(corr_count == 255, "R10 ceiling", corr_count, 255);

    // R7 all double errors over the 39 codeword bits
    for (int i = 0; i < 39; i++)
      for (int j = i + 1; j < 39; j++) begin
        new_data(i * 39 + j); clear_err();
        if (i < 32) ed[(i + j) % 4][i] = 1'b1; else ec[(i + j) % 4][i - 32] = 1'b1;
        if (j < 32) ed[(i + j) % 4][j] = 1'b1; else ec[(i + j) % 4][j - 32] = 1'b1;
        send_check("R7 double");
      end
    // R7 syndrome of weight seven
    new_data(77); clear_err();
    ec[2] = 7'h7F;
    send_check("R7 unmatched odd");

    // R7 held stream while halted
    new_data(78); clear_err();
    ed[0] = 32'h3;
    begin
      logic [31:0] cw;
      cw = '0;
      for (int i = 0; i < 4; i++) cw[7*i +: 7] = bchk(pd[i]);
      cap_n = 0;
      for (int i = 0; i < 4; i++) push(pd[i] ^ ed[i]);
      push(cw);
      repeat (3) @(negedge clk);
      in_valid = 1'b1;
      in_data = 32'hDEAD_BEEF;
      repeat (8) @(negedge clk);
      check(cap_n == 0 && !in_ready && fatal_error, "R7 stays halted", cap_n, 0);
      in_valid = 1'b0;
      pulse_start();
    end

    // R8 each pad bit
    for (int b = 0; b < 4; b++) begin
      new_data(90 + b); clear_err();
      pad[b] = 1'b1;
      send_check("R8 pad bit");
    end

    // R11 start drops a partial packet
    new_data(100);
    push(32'h1111_1111);
    push(32'h2222_2222);
    pulse_start();
    check(corr_count == exp_cnt, "R11 count after start", corr_count, exp_cnt);
    clear_err();
    ed[1][5] = 1'b1;
    send_check("R11 resume");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule